// File: doc/BRIEF.md
# Modulo Timer Counter with Coherent Byte Access

This block is a 16-bit up-counter that advances on a timer tick enable and wraps to zero at a programmable limit. When it wraps, it raises a sticky overflow flag. A CPU reaches the block through an 8-bit register bus. The bus exposes two read-only counter bytes, two read/write modulo bytes, and one control/status byte.

Because the bus is only eight bits wide, the block keeps 16-bit values coherent. Reading the counter high byte captures the low byte into a snapshot. That snapshot stays frozen until software reads the low byte. A write to the modulo high byte is only staged. The new 16-bit limit takes effect when the low byte is written. Between those two writes, overflow flagging and the overflow interrupt are held off.

Top module: `wrapTimer`

## Requirements
- R1: A read of the counter high byte (address 1) returns count bits 15:8. When no snapshot is held, the same read copies count bits 7:0 into a snapshot. The next read of address 2 returns that snapshot.
- R2: While a snapshot is held, further high-byte reads do not reload it. The snapshot persists however long the low byte goes unread. A read of address 2 releases it, and later reads of address 2 return the live count bits 7:0.
- R3: On a tick where the count equals the modulo limit, the count becomes 0x0000 and the overflow flag sets.
- R4: A write to address 3 stages the modulo high byte, and reads of address 3 return the staged byte. A write to address 4 loads the full limit {staged, data}, and address 4 reads back the limit's low byte. From the address-3 write until the address-4 write, the flag cannot set and the interrupt request stays low.
- R5: After reset, the count is 0x0000, both modulo bytes read 0xFF, and the flag and the interrupt enable are 0.
- R6: Writing address 0 with bit 5 set clears the count to 0x0000 in that cycle, overriding a tick. Bit 5 always reads back as 0.
- R7: Writes to addresses 1 and 2 leave the count and the snapshot unchanged.
- R8: The count increments by one only on cycles where tickEn is high, and holds otherwise.
- R9: Address 0 reads {flag, intEn, 000000}. A write to address 0 loads intEn from bit 6. The same write clears the flag when bit 7 is 0 and leaves it alone when bit 7 is 1. If a flag set and a clear happen together, the set wins. ovfIrq equals flag AND intEn AND not mid-update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer tick enable |
| busAddr | input | 3 | Register address |
| rdEn | input | 1 | Read strobe; side effects take place at the clock edge |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for busAddr, combinational |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a wrap that lands while a modulo update is half-written. The second is a snapshot held across repeated high-byte reads while the counter keeps running. The stimulus reaches both by keeping the modulo limit small, so that wraps come every few ticks. Random high-byte and low-byte modulo writes then interleave with those wraps, and the high-byte reads arrive in runs. Directed cases first pin down the exact wrap cycle, the stale snapshot and the set-over-clear priority.

// File: rtl/wrapTimerPkg.sv
package wrapTimerPkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_CNTHI = 3'd1,
    SEL_CNTLO = 3'd2,
    SEL_MODHI = 3'd3,
    SEL_MODLO = 3'd4
  } regSel_e;

  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int CLR_BIT  = 5;

  typedef struct packed {
    logic rdHi;
    logic rdLo;
    logic wrModHi;
    logic wrModLo;
    logic wrCtrl;
    logic cntClr;
    logic flagClr;
    logic ieVal;
  } strobe_t;
endpackage

// File: rtl/wrapTimerCtrl.sv
module wrapTimerCtrl
  import wrapTimerPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb,
  output regSel_e           rdSel
);
  logic isCtrl;

  always_comb begin
    rdSel        = regSel_e'(busAddr);
    isCtrl       = busAddr == SEL_CTRL;
    strb.rdHi    = rdEn && busAddr == SEL_CNTHI;
    strb.rdLo    = rdEn && busAddr == SEL_CNTLO;
    strb.wrModHi = wrEn && busAddr == SEL_MODHI;
    strb.wrModLo = wrEn && busAddr == SEL_MODLO;
    strb.wrCtrl  = wrEn && isCtrl;
    strb.cntClr  = wrEn && isCtrl && wrData[CLR_BIT];
    strb.flagClr = wrEn && isCtrl && !wrData[FLAG_BIT];
    strb.ieVal   = wrData[IE_BIT];
  end
endmodule

// File: rtl/wrapTimerDp.sv
module wrapTimerDp
  import wrapTimerPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  strobe_t           strb,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ovfFlag,
  output logic              ovfIrq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  modVal;
  logic [DATA_W-1:0] stage;
  logic [DATA_W-1:0] snap;
  logic              latched;
  logic              flag;
  logic              intEn;
  logic              inhibit;
  logic              hit;
  logic              wrapEv;

  assign hit    = count == modVal;
  assign wrapEv = tickEn && !strb.cntClr && hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      modVal  <= '1;
      stage   <= '1;
      snap    <= '0;
      latched <= 1'b0;
      flag    <= 1'b0;
      intEn   <= 1'b0;
      inhibit <= 1'b0;
    end else begin
      if (strb.cntClr)  count <= '0;
      else if (tickEn)  count <= hit ? '0 : count + 1'b1;

      if (wrapEv && !inhibit) flag <= 1'b1;
      else if (strb.flagClr)  flag <= 1'b0;

      if (strb.wrCtrl) intEn <= strb.ieVal;

      if (strb.rdHi && !latched) begin
        snap    <= count[DATA_W-1:0];
        latched <= 1'b1;
      end else if (strb.rdLo) begin
        latched <= 1'b0;
      end

      if (strb.wrModHi) begin
        stage   <= wrData;
        inhibit <= 1'b1;
      end else if (strb.wrModLo) begin
        modVal  <= {stage, wrData};
        inhibit <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_CTRL:  rdData = DATA_W'({flag, intEn} << (DATA_W - 2));
      SEL_CNTHI: rdData = count[CNT_W-1:DATA_W];
      SEL_CNTLO: rdData = latched ? snap : count[DATA_W-1:0];
      SEL_MODHI: rdData = stage;
      SEL_MODLO: rdData = modVal[DATA_W-1:0];
      default:   rdData = '0;
    endcase
  end

  assign ovfFlag = flag;
  assign ovfIrq  = flag && intEn && !inhibit;

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !strb.rdLo) |=> $stable(snap)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapEv |=> (count == '0)); // R3
  AST_NO_FLAG_INHIBITED: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit && !flag) |=> !flag); // R4
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (count == '0)); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.cntClr) |=> $stable(count)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strb.cntClr && !hit) |=> (count == $past(count) + 1'b1)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strb.flagClr) |=> flag); // R9
endmodule

// File: rtl/wrapTimer.sv
module wrapTimer
  import wrapTimerPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ovfFlag,
  output logic              ovfIrq
);
  strobe_t strb;
  regSel_e rdSel;

  wrapTimerCtrl #(.DATA_W(DATA_W)) ctrl (
    .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .strb(strb), .rdSel(rdSel)
  );

  wrapTimerDp #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .rdSel(rdSel),
    .wrData(wrData), .rdData(rdData), .ovfFlag(ovfFlag), .ovfIrq(ovfIrq)
  );
endmodule

// File: tb/wrapTimer_test.sv
module wrapTimer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ovfFlag;
  logic       ovfIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mCnt, mMod;
  logic [7:0]  mStage, mSnap;
  bit          mLatched, mFlag, mIe, mInh;

  wrapTimer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .ovfFlag(ovfFlag), .ovfIrq(ovfIrq)
  );

  always #2 clk = ~clk;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {mFlag, mIe, 6'b0};
      3'd1: return mCnt[15:8];
      3'd2: return mLatched ? mSnap : mCnt[7:0];
      3'd3: return mStage;
      3'd4: return mMod[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] a);
    case (a)
      3'd0: return "R9";
      3'd1: return "R1";
      3'd2: return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic modelReset();
    mCnt = 16'h0000; mMod = 16'hFFFF; mStage = 8'hFF; mSnap = 8'h00;
    mLatched = 0; mFlag = 0; mIe = 0; mInh = 0;
  endtask

  task automatic modelStep(input bit rd, input bit wr, input logic [2:0] a,
                           input logic [7:0] d, input bit tk);
    bit clr, wrap;
    logic [15:0] oldCnt;
    oldCnt = mCnt;
    clr  = wr && a == 3'd0 && d[5];
    wrap = 0;
    if (clr) mCnt = 16'h0;
    else if (tk) begin
      if (mCnt == mMod) begin mCnt = 16'h0; wrap = 1; end
      else mCnt = mCnt + 16'h1;
    end
    if (wrap && !mInh) mFlag = 1;
    else if (wr && a == 3'd0 && !d[7]) mFlag = 0;
    if (wr && a == 3'd0) mIe = d[6];
    if (rd && a == 3'd1 && !mLatched) begin mSnap = oldCnt[7:0]; mLatched = 1; end
    else if (rd && a == 3'd2) mLatched = 0;
    if (wr && a == 3'd3) begin mStage = d; mInh = 1; end
    else if (wr && a == 3'd4) begin mMod = {mStage, d}; mInh = 0; end
  endtask

  task automatic doCycle(input bit rd, input bit wr, input logic [2:0] a,
                         input logic [7:0] d, input bit tk, input string tag);
    @(negedge clk);
    chk({15'b0, ovfFlag}, {15'b0, mFlag}, "R9 flag");
    chk({15'b0, ovfIrq}, {15'b0, mFlag && mIe && !mInh}, "R4 R9 irq");
    rdEn = rd; wrEn = wr; busAddr = a; wrData = d; tickEn = tk;
    #1;
    if (rd) chk({8'b0, rdData}, {8'b0, expRead(a)}, tag);
    @(posedge clk);
    modelStep(rd, wr, a, d, tk);
  endtask

  task automatic rdReg(input logic [2:0] a, input bit tk, input string tag);
    doCycle(1, 0, a, 8'h00, tk, tag);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d, input bit tk);
    doCycle(0, 1, a, d, tk, "wr");
  endtask

  task automatic idle(input int n, input bit tk);
    for (int i = 0; i < n; i++) doCycle(0, 0, 3'd0, 8'h00, tk, "idle");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R5 reset values
    for (int a = 0; a < 5; a++) rdReg(3'(a), 0, "R5");
    // R8 no advance without tick, then five ticks
    idle(4, 0);
    rdReg(3'd2, 0, "R8");
    idle(5, 1);
    rdReg(3'd2, 0, "R8");
    // R1 snapshot and R2 freeze, stale value
    idle(200, 1);
    rdReg(3'd1, 1, "R1");
    idle(3, 1);
    rdReg(3'd1, 1, "R2");
    idle(40, 1);
    rdReg(3'd2, 1, "R1");
    rdReg(3'd2, 1, "R2");
    // R7 writes to counter bytes ignored
    rdReg(3'd1, 0, "R7");
    wrReg(3'd1, 8'hA5, 0);
    wrReg(3'd2, 8'h5A, 0);
    rdReg(3'd2, 0, "R7");
    rdReg(3'd1, 0, "R7");
    rdReg(3'd2, 0, "R7");
    // R6 counter clear overrides tick, bit 5 reads 0
    wrReg(3'd0, 8'hA0, 1);
    rdReg(3'd2, 0, "R6");
    rdReg(3'd0, 0, "R6");
    // R3 wrap at limit 5
    wrReg(3'd3, 8'h00, 0);
    wrReg(3'd4, 8'h05, 0);
    rdReg(3'd4, 0, "R4");
    idle(5, 1);
    rdReg(3'd2, 0, "R3");
    idle(1, 1);
    rdReg(3'd2, 0, "R3");
    rdReg(3'd0, 0, "R3");
    // R9 write with bit7=1 keeps flag, enable interrupt
    wrReg(3'd0, 8'hC0, 0);
    rdReg(3'd0, 0, "R9");
    wrReg(3'd0, 8'h40, 0);
    rdReg(3'd0, 0, "R9");
    // R4 half-written limit suppresses flag across several wraps
    wrReg(3'd3, 8'h00, 0);
    rdReg(3'd3, 0, "R4");
    idle(30, 1);
    rdReg(3'd0, 0, "R4");
    wrReg(3'd4, 8'h02, 0);
    rdReg(3'd4, 0, "R4");
    idle(12, 1);
    rdReg(3'd0, 0, "R4");
    // R9 set wins over simultaneous clear: wrap cycle aligned by model
    while (mCnt != mMod) idle(1, 1);
    wrReg(3'd0, 8'h40, 1);
    rdReg(3'd0, 0, "R9");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 99);
      bit tk = $urandom_range(0, 9) < 7;
      logic [2:0] a = 3'($urandom_range(0, 4));
      logic [7:0] d = 8'($urandom);
      if (op < 45) idle(1, tk);
      else if (op < 80) rdReg(a, tk, tagOf(a));
      else if (op < 86) wrReg(3'd0, {d[7:6], ($urandom_range(0, 7) == 0), 5'b0}, tk);
      else if (op < 91) wrReg(3'd3, 8'h00, tk);
      else if (op < 96) wrReg(3'd4, 8'($urandom_range(2, 30)), tk);
      else wrReg(3'($urandom_range(1, 2)), d, tk);
    end
    idle(2, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule